// File: doc/BRIEF.md
# DMA Channel Control and Service Scanner

This block holds the control state of a four-channel DMA engine and decides which channels are granted service. A 3-bit control port index, a write strobe and a data byte program it. Through that interface it takes a command byte, four per-channel mode bytes, a four-bit channel mask, software request bits and a byte-order flip-flop. Hardware request hold and release pulses, and terminal-count pulses from the data path, update a shared status byte. Request flags sit in its upper half and terminal-count flags in its lower half.

A scan is started with a single-cycle `scan_go` pulse. The scanner then visits channels 0, 1, 2 and 3 in that order, one per cycle. It pulses the service strobe of a visited channel when that channel is unmasked and has its request flag set at that moment. A start pulse that arrives while a scan is still running is discarded. A command byte that enables any unsupported feature is refused. The command register then keeps its old value, and a sticky error flag is raised.

Top module: `dma_ctl_scan`

## Requirements
- R1: In the first cycle after synchronous reset, `mask_q` is 4'hF, while `status_q`, `cmd_q`, `mode_q`, `flop_q`, `cmd_err`, `svc_strobe` and `scan_busy` are all zero.
- R2: A write to port 0 stores the data byte into `cmd_q` when the byte is zero or only bit 2 is set.
- R3: A port 0 write with any bit other than bit 2 set leaves `cmd_q` unchanged and sets `cmd_err`. Only reset clears `cmd_err`.
- R4: A write to port 1 takes the channel number from data bits 1:0. It sets `status_q[ch+4]` when data bit 2 is 1 and clears it when data bit 2 is 0. In both cases it clears `status_q[ch]`.
- R5: A write to port 2 sets `mask_q[ch]` to data bit 2, where ch is data bits 1:0.
- R6: A write to port 3 stores the whole byte into the mode byte of channel data[1:0], at `mode_q[ch*8 +: 8]`. Within that byte, bits 1:0 are the channel, bits 3:2 the operation, bit 4 auto-reinit, bit 5 downward addressing and bits 7:6 the transfer mode.
- R7: A write to port 4 clears `flop_q`. Otherwise a `byte_toggle` pulse inverts `flop_q`, and a port 4 or port 5 write takes precedence over a toggle in the same cycle.
- R8: A write to port 5 sets `mask_q` to 4'hF and clears `status_q`, `cmd_q` and `flop_q`. It leaves the mode bytes and `cmd_err` untouched.
- R9: A write to port 6 clears all four mask bits. A write to port 7 loads `mask_q` from data bits 3:0.
- R10: `hold_req[i]` sets `status_q[i+4]`. `release_req[i]` without hold clears it, and hold wins when both are high. `tc_flag[i]` sets `status_q[i]`. These hardware pulses are applied after any control write in the same cycle.
- R11: A `scan_go` accepted while idle makes `scan_busy` high for exactly four cycles, with channel k visited in the (k+1)-th of them. During the visit to channel k, `svc_strobe[k]` is high if and only if `mask_q[k]` is 0 and `status_q[k+4]` is 1. At most one strobe bit is ever high.
- R12: A `scan_go` pulse that arrives while `scan_busy` is high is ignored. It neither restarts nor extends the running scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_sel | input | 3 | Control port index 0..7 |
| ctl_data | input | 8 | Control write data |
| byte_toggle | input | 1 | Data-path byte access, flips the byte-order flip-flop |
| hold_req | input | 4 | Per-channel hardware request raise pulse |
| release_req | input | 4 | Per-channel hardware request drop pulse |
| tc_flag | input | 4 | Per-channel terminal-count pulse |
| scan_go | input | 1 | Start a service scan |
| svc_strobe | output | 4 | One-cycle service grant per channel |
| scan_busy | output | 1 | Scan in progress |
| mask_q | output | 4 | Channel mask, 1 = masked |
| status_q | output | 8 | Requests in bits 7:4, terminal counts in bits 3:0 |
| cmd_q | output | 8 | Command register |
| mode_q | output | 32 | Four mode bytes, channel k at bits k*8+7:k*8 |
| flop_q | output | 1 | Byte-order flip-flop |
| cmd_err | output | 1 | Sticky flag for a refused command |

## Verification
The bench builds the block with its default four channels and 8-bit bytes. With those values the 2-bit channel field addresses every channel, so the port 7 all-mask load and the scan counter's wrap from channel 3 back to idle are both reached. Randomised traffic, weighted toward collisions, runs after the directed sequences. It lands software request writes, hardware hold, release and terminal-count pulses, mask changes and start pulses in the same cycle as a scan visit. Each of these cases is compared against the behavioural model on every clock.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int DW   = 8;
    localparam int CH_W = 2;
    localparam int NCH  = 1 << CH_W;

    // Bits of the command byte that may be set; everything else is refused.
    localparam logic [DW-1:0] CMD_LEGAL_MASK = 8'h04;

    typedef enum logic [2:0] {
        PORT_CMD      = 3'd0,
        PORT_REQ      = 3'd1,
        PORT_MASK_ONE = 3'd2,
        PORT_MODE     = 3'd3,
        PORT_FLOP_CLR = 3'd4,
        PORT_MASTER   = 3'd5,
        PORT_MASK_CLR = 3'd6,
        PORT_MASK_SET = 3'd7
    } ctl_port_e;

    typedef struct packed {
        logic            cmd_wr;
        logic            req_wr;
        logic            mask_one_wr;
        logic            mode_wr;
        logic            flop_clr;
        logic            master_clr;
        logic            mask_clr;
        logic            mask_set;
        logic [CH_W-1:0] chan;
        logic            bitv;
        logic [DW-1:0]   data;
    } ctl_op_t;

    function automatic logic cmd_acceptable(input logic [DW-1:0] v);
        return (v & ~CMD_LEGAL_MASK) == '0;
    endfunction

    function automatic ctl_op_t decode_ctl(input logic wr,
                                           input logic [2:0] sel,
                                           input logic [DW-1:0] d);
        ctl_op_t o;
        o = '0;
        o.chan = d[CH_W-1:0];
        o.bitv = d[2];
        o.data = d;
        if (wr) begin
            unique case (ctl_port_e'(sel))
                PORT_CMD:      o.cmd_wr      = 1'b1;
                PORT_REQ:      o.req_wr      = 1'b1;
                PORT_MASK_ONE: o.mask_one_wr = 1'b1;
                PORT_MODE:     o.mode_wr     = 1'b1;
                PORT_FLOP_CLR: o.flop_clr    = 1'b1;
                PORT_MASTER:   o.master_clr  = 1'b1;
                PORT_MASK_CLR: o.mask_clr    = 1'b1;
                PORT_MASK_SET: o.mask_set    = 1'b1;
                default:       o.cmd_wr      = 1'b0;
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = NCH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_wr,
    input  logic                   mask_one_wr,
    input  logic                   mode_wr,
    input  logic                   flop_clr,
    input  logic                   master_clr,
    input  logic                   mask_clr,
    input  logic                   mask_set,
    input  logic [CH_W-1:0]        chan,
    input  logic                   bitv,
    input  logic [DW-1:0]          data,
    input  logic                   byte_toggle,
    output logic [NUM_CH-1:0]      mask_q,
    output logic [DW-1:0]          cmd_q,
    output logic [NUM_CH*DW-1:0]   mode_q,
    output logic                   flop_q,
    output logic                   cmd_err
);

    logic [NUM_CH-1:0] mask_r;
    logic [DW-1:0]     cmd_r;
    logic [DW-1:0]     mode_r [NUM_CH];
    logic              flop_r;
    logic              err_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_r <= '1;
            cmd_r  <= '0;
            flop_r <= 1'b0;
            err_r  <= 1'b0;
            for (int i = 0; i < NUM_CH; i++) mode_r[i] <= '0;
        end else begin
            if (cmd_wr) begin
                if (cmd_acceptable(data)) cmd_r <= data;
                else                      err_r <= 1'b1;
            end
            if (master_clr) cmd_r <= '0;

            if (mask_one_wr) mask_r[chan] <= bitv;
            if (mask_clr)    mask_r <= '0;
            if (mask_set)    mask_r <= data[NUM_CH-1:0];
            if (master_clr)  mask_r <= '1;

            if (mode_wr) mode_r[chan] <= data;

            if (flop_clr || master_clr) flop_r <= 1'b0;
            else if (byte_toggle)       flop_r <= ~flop_r;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode_out
        assign mode_q[g*DW +: DW] = mode_r[g];
    end

    assign mask_q  = mask_r;
    assign cmd_q   = cmd_r;
    assign flop_q  = flop_r;
    assign cmd_err = err_r;

    // R8: master clear masks every channel on the next cycle
    assert_master_masks_R8: assert property (@(posedge clk) disable iff (rst)
        master_clr |=> (mask_q == '1));

    // R3: the error flag never falls outside reset
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);

    // R3: a refused command leaves the register as it was
    assert_bad_cmd_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_acceptable(data)) |=> $stable(cmd_q));

    // R2: the command register only ever holds a legal value
    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_acceptable(cmd_q));

    // R7: a clear write wins over a toggle
    assert_flop_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (flop_clr && byte_toggle) |=> !flop_q);

endmodule

// File: rtl/dma_req_status.sv
module dma_req_status
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = NCH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_wr,
    input  logic                  master_clr,
    input  logic [CH_W-1:0]       chan,
    input  logic                  bitv,
    input  logic [NUM_CH-1:0]     hold_req,
    input  logic [NUM_CH-1:0]     release_req,
    input  logic [NUM_CH-1:0]     tc_flag,
    output logic [2*NUM_CH-1:0]   status_q
);

    logic [2*NUM_CH-1:0] stat_r;
    logic [2*NUM_CH-1:0] stat_nxt;

    always_comb begin
        stat_nxt = stat_r;
        // Control-port effects first
        if (req_wr) begin
            stat_nxt[NUM_CH + int'(chan)] = bitv;
            stat_nxt[int'(chan)]          = 1'b0;
        end
        if (master_clr) stat_nxt = '0;
        // Hardware pulses on top
        for (int i = 0; i < NUM_CH; i++) begin
            if (tc_flag[i])          stat_nxt[i] = 1'b1;
            if (hold_req[i])         stat_nxt[NUM_CH+i] = 1'b1;
            else if (release_req[i]) stat_nxt[NUM_CH+i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_r <= '0;
        else     stat_r <= stat_nxt;
    end

    assign status_q = stat_r;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R10: a hold pulse always leaves the request flag set
        assert_hold_sets_R10: assert property (@(posedge clk) disable iff (rst)
            hold_req[g] |=> status_q[NUM_CH+g]);
        // R10: a lone release always leaves the request flag clear
        assert_release_clears_R10: assert property (@(posedge clk) disable iff (rst)
            (release_req[g] && !hold_req[g]) |=> !status_q[NUM_CH+g]);
        // R10: terminal count flag is set after a tc pulse
        assert_tc_sets_R10: assert property (@(posedge clk) disable iff (rst)
            tc_flag[g] |=> status_q[g]);
    end

endmodule

// File: rtl/dma_svc_scan.sv
module dma_svc_scan
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_go,
    input  logic [NUM_CH-1:0] mask,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] svc_strobe,
    output logic              scan_busy
);

    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IW-1:0] LAST = IW'(NUM_CH - 1);

    logic          busy_r;
    logic [IW-1:0] idx_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_r <= 1'b0;
            idx_r  <= '0;
        end else if (busy_r) begin
            if (idx_r == LAST) begin
                busy_r <= 1'b0;
                idx_r  <= '0;
            end else begin
                idx_r <= idx_r + 1'b1;
            end
        end else if (scan_go) begin
            busy_r <= 1'b1;
            idx_r  <= '0;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_svc
        assign svc_strobe[g] = busy_r && (idx_r == IW'(g)) && !mask[g] && req[g];
    end

    assign scan_busy = busy_r;

    // R11: at most one channel granted per cycle
    assert_one_grant_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc_strobe));

    // R12: a scan only begins after a start pulse seen while idle
    assert_start_needs_go_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_busy) |-> $past(scan_go));

    // R11: the scan does not end before the last channel is visited
    assert_full_sweep_R11: assert property (@(posedge clk) disable iff (rst)
        (scan_busy && idx_r != LAST) |=> scan_busy);

    // R11: the scan ends right after the last channel
    assert_sweep_ends_R11: assert property (@(posedge clk) disable iff (rst)
        (scan_busy && idx_r == LAST) |=> !scan_busy);

endmodule

// File: rtl/dma_ctl_scan.sv
module dma_ctl_scan
    import dma_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_wr,
    input  logic [2:0]      ctl_sel,
    input  logic [7:0]      ctl_data,
    input  logic            byte_toggle,
    input  logic [3:0]      hold_req,
    input  logic [3:0]      release_req,
    input  logic [3:0]      tc_flag,
    input  logic            scan_go,
    output logic [3:0]      svc_strobe,
    output logic            scan_busy,
    output logic [3:0]      mask_q,
    output logic [7:0]      status_q,
    output logic [7:0]      cmd_q,
    output logic [31:0]     mode_q,
    output logic            flop_q,
    output logic            cmd_err
);

    ctl_op_t op;
    assign op = decode_ctl(ctl_wr, ctl_sel, ctl_data);

    dma_ctl_regs #(.NUM_CH(NCH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (op.cmd_wr),
        .mask_one_wr (op.mask_one_wr),
        .mode_wr     (op.mode_wr),
        .flop_clr    (op.flop_clr),
        .master_clr  (op.master_clr),
        .mask_clr    (op.mask_clr),
        .mask_set    (op.mask_set),
        .chan        (op.chan),
        .bitv        (op.bitv),
        .data        (op.data),
        .byte_toggle (byte_toggle),
        .mask_q      (mask_q),
        .cmd_q       (cmd_q),
        .mode_q      (mode_q),
        .flop_q      (flop_q),
        .cmd_err     (cmd_err)
    );

    dma_req_status #(.NUM_CH(NCH)) u_status (
        .clk         (clk),
        .rst         (rst),
        .req_wr      (op.req_wr),
        .master_clr  (op.master_clr),
        .chan        (op.chan),
        .bitv        (op.bitv),
        .hold_req    (hold_req),
        .release_req (release_req),
        .tc_flag     (tc_flag),
        .status_q    (status_q)
    );

    dma_svc_scan #(.NUM_CH(NCH)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .scan_go    (scan_go),
        .mask       (mask_q),
        .req        (status_q[2*NCH-1:NCH]),
        .svc_strobe (svc_strobe),
        .scan_busy  (scan_busy)
    );

endmodule

// File: tb/tb_dma_ctl_scan.sv
module tb_dma_ctl_scan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_sel = '0;
    logic [7:0]  ctl_data = '0;
    logic        byte_toggle = 1'b0;
    logic [3:0]  hold_req = '0;
    logic [3:0]  release_req = '0;
    logic [3:0]  tc_flag = '0;
    logic        scan_go = 1'b0;
    logic [3:0]  svc_strobe;
    logic        scan_busy;
    logic [3:0]  mask_q;
    logic [7:0]  status_q;
    logic [7:0]  cmd_q;
    logic [31:0] mode_q;
    logic        flop_q;
    logic        cmd_err;

    always #4 clk = ~clk;   // 125 MHz

    dma_ctl_scan dut (.*);

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference state
    int m_mask, m_status, m_cmd, m_err, m_flop, m_busy, m_idx;
    int m_mode [4];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mask = 15; m_status = 0; m_cmd = 0; m_err = 0; m_flop = 0;
            m_busy = 0; m_idx = 0;
            for (int i = 0; i < 4; i++) m_mode[i] = 0;
        end else begin
            int d, ch, nf;
            d  = int'(ctl_data);
            ch = d & 3;
            if (m_busy != 0) begin
                if (m_idx == 3) begin m_busy = 0; m_idx = 0; end
                else m_idx++;
            end else if (scan_go) begin
                m_busy = 1; m_idx = 0;
            end
            nf = byte_toggle ? (1 - m_flop) : m_flop;
            if (ctl_wr) begin
                case (int'(ctl_sel))
                    0: if ((d & 'hFB) == 0) m_cmd = d; else m_err = 1;
                    1: begin
                        if ((d & 4) != 0) m_status |= (1 << (ch + 4));
                        else              m_status &= ~(1 << (ch + 4));
                        m_status &= ~(1 << ch);
                    end
                    2: if ((d & 4) != 0) m_mask |= (1 << ch); else m_mask &= ~(1 << ch);
                    3: m_mode[ch] = d;
                    4: nf = 0;
                    5: begin m_mask = 15; m_status = 0; m_cmd = 0; nf = 0; end
                    6: m_mask = 0;
                    default: m_mask = d & 15;
                endcase
            end
            m_flop = nf;
            for (int i = 0; i < 4; i++) begin
                if (tc_flag[i]) m_status |= (1 << i);
                if (hold_req[i])         m_status |= (1 << (i + 4));
                else if (release_req[i]) m_status &= ~(1 << (i + 4));
            end
            m_status &= 255;
        end
        started = 1;
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_svc, exp_mode;
            exp_svc = 0;
            if (m_busy != 0 && ((m_mask >> m_idx) & 1) == 0 && ((m_status >> (m_idx + 4)) & 1) == 1)
                exp_svc = 1 << m_idx;
            exp_mode = 0;
            for (int i = 0; i < 4; i++) exp_mode |= (m_mode[i] << (8 * i));
            chk("R5 R8 R9 mask", longint'(mask_q), longint'(m_mask));
            chk("R4 R10 status", longint'(status_q), longint'(m_status));
            chk("R2 R3 R8 cmd", longint'(cmd_q), longint'(m_cmd));
            chk("R3 cmd_err", longint'(cmd_err), longint'(m_err));
            chk("R6 mode", longint'(mode_q), longint'(unsigned'(exp_mode)));
            chk("R7 flop", longint'(flop_q), longint'(m_flop));
            chk("R11 svc_strobe", longint'(svc_strobe), longint'(exp_svc));
            chk("R12 scan_busy", longint'(scan_busy), longint'(m_busy));
        end
    end

    task automatic idle_inputs();
        ctl_wr = 0; ctl_sel = 0; ctl_data = 0; byte_toggle = 0;
        hold_req = 0; release_req = 0; tc_flag = 0; scan_go = 0;
    endtask

    task automatic wr(input int port, input int val);
        @(negedge clk);
        idle_inputs();
        ctl_wr = 1; ctl_sel = 3'(port); ctl_data = 8'(val);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic go();
        @(negedge clk);
        idle_inputs();
        scan_go = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state, checked explicitly as well
        chk("R1 mask", longint'(mask_q), 15);
        chk("R1 status", longint'(status_q), 0);
        chk("R1 busy", longint'(scan_busy), 0);
        chk("R1 err", longint'(cmd_err), 0);

        // R2 / R3 command writes
        wr(0, 'h04);
        wr(0, 'h00);
        wr(0, 'h04);
        wr(0, 'h10);          // refused
        wr(0, 'h00);
        // R6 mode bytes for every channel
        for (int c = 0; c < 4; c++) wr(3, (c * 'h44) ^ 'hA8 | c);
        // R4 request writes, R5 single masks, R9 bulk masks
        wr(6, 0);
        wr(1, 'h04); wr(1, 'h06); wr(1, 'h03);
        wr(2, 'h05);
        wr(7, 'h0A);
        wr(6, 0);
        // R11 scan with channels 0 and 2 requesting
        go();
        repeat (2) @(negedge clk);
        // R12 go during busy ignored
        scan_go = 1; @(negedge clk); idle_inputs();
        repeat (4) @(negedge clk);
        // R10 hold/release/tc, with hold+release collision
        @(negedge clk); hold_req = 4'b1010; tc_flag = 4'b0101;
        @(negedge clk); idle_inputs(); hold_req = 4'b0010; release_req = 4'b1010;
        @(negedge clk); idle_inputs();
        // R7 toggle and clear priority
        @(negedge clk); byte_toggle = 1;
        @(negedge clk); byte_toggle = 1; ctl_wr = 1; ctl_sel = 4;
        @(negedge clk); idle_inputs(); byte_toggle = 1;
        @(negedge clk); idle_inputs();
        // R8 master clear
        wr(5, 0);
        go();
        repeat (5) @(negedge clk);

        // Random collisions
        for (int n = 0; n < 4000; n++) begin
            int r;
            @(negedge clk);
            idle_inputs();
            r = int'($urandom_range(0, 99));
            if (r < 45) begin
                ctl_wr = 1;
                ctl_sel = 3'($urandom_range(0, 7));
                if (ctl_sel == 3'd5 && $urandom_range(0, 3) != 0) ctl_sel = 3'd1;
                case ($urandom_range(0, 2))
                    0: ctl_data = 8'h04;
                    1: ctl_data = 8'($urandom_range(0, 7));
                    default: ctl_data = 8'($urandom());
                endcase
            end
            if ($urandom_range(0, 3) == 0) hold_req = 4'($urandom());
            if ($urandom_range(0, 3) == 0) release_req = 4'($urandom());
            if ($urandom_range(0, 5) == 0) tc_flag = 4'($urandom());
            byte_toggle = ($urandom_range(0, 3) == 0);
            scan_go = ($urandom_range(0, 2) == 0);
        end
        @(negedge clk);
        idle_inputs();
        repeat (6) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule